// File: doc/BRIEF.md
# MDIO Paged Management Register Slave

This block is the management-port slave of a PHY-style device. It watches the two-wire management bus (a clock driven by the station manager and one bidirectional data line) and decodes clause-22 frames addressed to its strapped 5-bit PHY address. Read frames return a 16-bit register value. Write frames update a register. The bidirectional data line is split into an input, an output and an output enable, so the pad and its pull-up stay outside the block.

The register file mixes several access types. It has control bits that the rest of the device uses, a self-clearing restart bit, a latch-high fault bit and a saturating error counter that clears when read. It also has an interrupt register that pairs per-event enables with status bits that clear when read. A page register remaps the upper address range 14h–1Fh, so the same addresses reach different registers on different pages. The whole block runs on a fast system clock and oversamples the management clock. Event strobes from the device are therefore caught even while the management clock is stopped.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones have been sampled on the data line, followed by the start pattern 0 then 1. A frame that follows a shorter run of ones is ignored. So is a frame whose start pattern is 0 then 0, or whose opcode is 11 or 00. Read is opcode 10 and write is opcode 01, each sent MSB first.
- R2: In a read frame the slave leaves the line undriven during the first turnaround bit. It drives 0 for the second turnaround bit and then drives 16 data bits, MSB first, one per management-clock rising edge. It releases the line after the last data bit.
- R3: The slave acts only on frames whose PHY address field equals `phy_addr_i`. A frame for another address never enables the output and changes no register.
- R4: A write changes the addressed register only after the 16th data bit has been sampled. Writes to read-only bits and read-only registers have no effect.
- R5: Bits [2:0] of register 13h select the page and reset to 0. The other bits of 13h read 0. On page p < N_PAGES, address 16h is a 16-bit read-write register whose value appears on `page_cfg_o[16p+15:16p]`. Address 15h holds the error counter on page 0 only. Every other paged location reads 0.
- R6: Register 00h holds loopback at bit 14 (reset 0), speed at bit 13 (reset 1), auto-negotiation enable at bit 12 (reset 1) and duplex at bit 8 (reset 0). The reset value is therefore 3000h. Writing 1 to bit 9 gives a one-cycle pulse on `an_restart_o` only if bit 12 of the written word is 1. Bit 9 always reads 0.
- R7: Register 01h reads 7801h, with bit 4 and bit 2 added. Bit 4 is set by `remote_fault_i`, stays set after the fault goes away, and clears after a read of 01h. Bit 2 follows `link_up_i`.
- R8: Register 15h on page 0 counts cycles in which `ev_i[0]` (receive error) is high, in bits [7:0]. The count saturates at 255 and clears after a read. Bits [15:8] read 0, and writes have no effect.
- R9: In register 12h, bit i is the enable and bit 8+i is the status of event `ev_i[i]`. A status bit is set by its event whether or not it is enabled, and clears after a read of 12h. `irq_o` is high exactly when some status bit and its enable are both set.
- R10: After reset the data output is not enabled, `an_restart_o` and `irq_o` are low, and `page_cfg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the management-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven when enabled |
| mdio_oe_o | output | 1 | Output enable for the data line |
| phy_addr_i | input | 5 | Strapped PHY address |
| link_up_i | input | 1 | Live link state |
| remote_fault_i | input | 1 | Remote fault condition (level) |
| ev_i | input | N_EVT | Event strobes: 0 receive error, 1 link change, 2 remote fault, 3 negotiation done |
| an_enable_o | output | 1 | Auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle negotiation restart pulse |
| loopback_o | output | 1 | Loopback control |
| speed_o | output | 1 | Speed select |
| duplex_o | output | 1 | Duplex select |
| page_cfg_o | output | N_PAGES*16 | Per-page configuration words |
| irq_o | output | 1 | Interrupt request |

## Verification
Most wrong internal states surface at the ports within one frame. A frame engine that is out of step with the bit stream shows up in the next read as a missing or misplaced turnaround zero, or as data shifted by one bit. A wrong page decode returns another page's word, or a nonzero value from a location that should read 0. Faults in the clear-on-read and latch logic are hidden until a second read: the first read must show the event and the second must show it gone. The counter's saturation is therefore checked by reading it twice across more than 255 events. Interrupt gating can be seen on `irq_o` one system clock after a strobe, and again one clock after the status register is read.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and types for the management-port slave.
// Assumes clause-22 framing with a 5-bit PHY and register address.
package mdio_mgmt_pkg;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned REG_AW  = 5;
    localparam int unsigned PHY_AW  = 5;
    localparam int unsigned PAGE_W  = 3;
    localparam int unsigned PRE_LEN = 32;

    typedef enum logic [2:0] {
        FR_HUNT, FR_START, FR_HDR, FR_TA1, FR_TA2, FR_RD, FR_WR
    } frame_st_e;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [REG_AW-1:0] A_CTRL   = 5'h00;
    localparam logic [REG_AW-1:0] A_STAT   = 5'h01;
    localparam logic [REG_AW-1:0] A_IRQ    = 5'h12;
    localparam logic [REG_AW-1:0] A_PAGE   = 5'h13;
    localparam logic [REG_AW-1:0] A_ERRCNT = 5'h15;
    localparam logic [REG_AW-1:0] A_PCFG   = 5'h16;

    localparam int unsigned CB_LOOP    = 14;
    localparam int unsigned CB_SPEED   = 13;
    localparam int unsigned CB_AN      = 12;
    localparam int unsigned CB_RESTART = 9;
    localparam int unsigned CB_DUPLEX  = 8;

    localparam logic [DATA_W-1:0] STAT_FIXED = 16'h7801;
    localparam int unsigned SB_FAULT = 4;
    localparam int unsigned SB_LINK  = 2;

    localparam int unsigned IRQ_STS_LSB = 8;
endpackage

// File: rtl/mdio_pin_sync.sv
// Brings the management clock and data line into the system clock domain.
// Emits a one-cycle strobe per management-clock rising edge together with
// the data value sampled alongside it. Assumes clk runs at least 4x faster.
module mdio_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic bit_stb,
    output logic bit_val
);
    logic [STAGES:0]   mdc_q;
    logic [STAGES-1:0] dat_q;

    // Purpose: shift both pins through equal-depth synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= '0;
            dat_q <= '1;
        end else begin
            mdc_q <= {mdc_q[STAGES-1:0], mdc_i};
            dat_q <= {dat_q[STAGES-2:0], mdio_i};
        end
    end

    assign bit_stb = mdc_q[STAGES-1] & ~mdc_q[STAGES];
    assign bit_val = dat_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: hunts for the preamble, checks start, opcode and PHY
// address, then issues a read or write strobe to the register bank and
// drives the read reply. Assumes bit strobes are at least 3 clocks apart.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [PHY_AW-1:0] phy_addr_i,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int unsigned HDR_W  = 2 + PHY_AW + REG_AW;
    localparam int unsigned PRE_CW = $clog2(PRE_LEN + 1);
    localparam int unsigned BC_W   = $clog2(HDR_W > DATA_W ? HDR_W : DATA_W);

    frame_st_e         st_q;
    logic [PRE_CW-1:0] pre_q;
    logic [BC_W-1:0]   bc_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] sr_q;
    logic              is_rd_q, oe_q, out_q, rstb_q, wstb_q;
    logic [REG_AW-1:0] addr_q;

    logic [HDR_W-1:0]  hdr_nx;
    logic [1:0]        op_nx;
    logic [PHY_AW-1:0] phy_nx;
    logic              hit_nx;

    // Purpose: decode the header as it would look after the current bit.
    always_comb begin
        hdr_nx = {hdr_q[HDR_W-2:0], bit_val};
        op_nx  = hdr_nx[HDR_W-1 -: 2];
        phy_nx = hdr_nx[REG_AW +: PHY_AW];
        hit_nx = (phy_nx == phy_addr_i) && (op_nx == OP_RD || op_nx == OP_WR);
    end

    // Purpose: advance the frame state on each sampled management bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= FR_HUNT;
            pre_q   <= '0;
            bc_q    <= '0;
            hdr_q   <= '0;
            sr_q    <= '0;
            is_rd_q <= 1'b0;
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            rstb_q  <= 1'b0;
            wstb_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            rstb_q <= 1'b0;
            wstb_q <= 1'b0;
            if (rstb_q) begin
                sr_q <= rd_data;
            end
            if (bit_stb) begin
                case (st_q)
                    FR_HUNT: begin
                        if (bit_val) begin
                            if (pre_q != PRE_CW'(PRE_LEN)) pre_q <= pre_q + 1'b1;
                        end else begin
                            pre_q <= '0;
                            if (pre_q == PRE_CW'(PRE_LEN)) st_q <= FR_START;
                        end
                    end
                    FR_START: begin
                        bc_q <= '0;
                        st_q <= bit_val ? FR_HDR : FR_HUNT;
                    end
                    FR_HDR: begin
                        hdr_q <= hdr_nx;
                        if (bc_q == BC_W'(HDR_W - 1)) begin
                            bc_q    <= '0;
                            addr_q  <= hdr_nx[REG_AW-1:0];
                            is_rd_q <= (op_nx == OP_RD);
                            rstb_q  <= hit_nx && (op_nx == OP_RD);
                            st_q    <= hit_nx ? FR_TA1 : FR_HUNT;
                        end else begin
                            bc_q <= bc_q + 1'b1;
                        end
                    end
                    FR_TA1: begin
                        st_q <= FR_TA2;
                        if (is_rd_q) begin
                            oe_q  <= 1'b1;
                            out_q <= 1'b0;
                        end
                    end
                    FR_TA2: begin
                        bc_q <= '0;
                        if (is_rd_q) begin
                            st_q  <= FR_RD;
                            out_q <= sr_q[DATA_W-1];
                            sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
                        end else begin
                            st_q <= FR_WR;
                        end
                    end
                    FR_RD: begin
                        if (bc_q == BC_W'(DATA_W - 1)) begin
                            oe_q  <= 1'b0;
                            out_q <= 1'b0;
                            st_q  <= FR_HUNT;
                        end else begin
                            bc_q  <= bc_q + 1'b1;
                            out_q <= sr_q[DATA_W-1];
                            sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
                        end
                    end
                    FR_WR: begin
                        sr_q <= {sr_q[DATA_W-2:0], bit_val};
                        if (bc_q == BC_W'(DATA_W - 1)) begin
                            wstb_q <= 1'b1;
                            st_q   <= FR_HUNT;
                        end else begin
                            bc_q <= bc_q + 1'b1;
                        end
                    end
                    default: st_q <= FR_HUNT;
                endcase
            end
        end
    end

    assign rd_stb    = rstb_q;
    assign wr_stb    = wstb_q;
    assign reg_addr  = addr_q;
    assign wr_data   = sr_q;
    assign mdio_o    = out_q;
    assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_sat_cor_counter.sv
// Saturating event counter that clears when read.
// An event in the same cycle as the clear is kept as a count of one.
module mdio_sat_cor_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    // Purpose: count up to the top value, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? W'(1) : '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/mdio_reg_bank.sv
// Register bank behind the frame engine: control, status with a latch-high
// fault bit, interrupt enables and status, page select, and paged space
// with a saturating error counter and one config word per page.
// Assumes rd_stb and wr_stb are single-cycle and never coincide.
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned N_PAGES = 2,
    parameter int unsigned N_EVT   = 4,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_stb,
    input  logic                      wr_stb,
    input  logic [REG_AW-1:0]         addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      link_up_i,
    input  logic                      remote_fault_i,
    input  logic [N_EVT-1:0]          ev_i,
    output logic                      an_enable_o,
    output logic                      an_restart_o,
    output logic                      loopback_o,
    output logic                      speed_o,
    output logic                      duplex_o,
    output logic [N_PAGES*DATA_W-1:0] page_cfg_o,
    output logic                      irq_o
);
    logic              loop_q, speed_q, an_q, duplex_q, restart_q;
    logic              fault_q;
    logic [N_EVT-1:0]  sts_q, en_q;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] cfg_q [N_PAGES];
    logic [CNT_W-1:0]  err_cnt;
    logic              page0, wr_ctrl;

    assign page0   = (page_q == '0);
    assign wr_ctrl = wr_stb && (addr == A_CTRL);

    // Purpose: hold the control bits and raise the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q    <= 1'b0;
            speed_q   <= 1'b1;
            an_q      <= 1'b1;
            duplex_q  <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= wr_ctrl && wr_data[CB_RESTART] && wr_data[CB_AN];
            if (wr_ctrl) begin
                loop_q   <= wr_data[CB_LOOP];
                speed_q  <= wr_data[CB_SPEED];
                an_q     <= wr_data[CB_AN];
                duplex_q <= wr_data[CB_DUPLEX];
            end
        end
    end

    // Purpose: latch the remote fault high until the status register is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= remote_fault_i | (fault_q & ~(rd_stb && addr == A_STAT));
        end
    end

    // Purpose: record events, clear status on read, hold the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= ev_i | (sts_q & ~{N_EVT{rd_stb && addr == A_IRQ}});
            if (wr_stb && addr == A_IRQ) en_q <= wr_data[N_EVT-1:0];
        end
    end

    // Purpose: hold the page select and the per-page config words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            for (int p = 0; p < N_PAGES; p++) cfg_q[p] <= '0;
        end else if (wr_stb) begin
            if (addr == A_PAGE) page_q <= wr_data[PAGE_W-1:0];
            for (int p = 0; p < N_PAGES; p++) begin
                if (addr == A_PCFG && page_q == PAGE_W'(p)) cfg_q[p] <= wr_data;
            end
        end
    end

    mdio_sat_cor_counter #(.W(CNT_W)) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ev_i[0]),
        .clr   (rd_stb && addr == A_ERRCNT && page0),
        .count (err_cnt)
    );

    // Purpose: select the read value for the addressed register and page.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL: begin
                rd_data[CB_LOOP]   = loop_q;
                rd_data[CB_SPEED]  = speed_q;
                rd_data[CB_AN]     = an_q;
                rd_data[CB_DUPLEX] = duplex_q;
            end
            A_STAT: begin
                rd_data           = STAT_FIXED;
                rd_data[SB_FAULT] = fault_q;
                rd_data[SB_LINK]  = link_up_i;
            end
            A_IRQ: begin
                rd_data[IRQ_STS_LSB +: N_EVT] = sts_q;
                rd_data[0 +: N_EVT]           = en_q;
            end
            A_PAGE:   rd_data[PAGE_W-1:0] = page_q;
            A_ERRCNT: if (page0) rd_data[CNT_W-1:0] = err_cnt;
            default:  ;
        endcase
        for (int p = 0; p < N_PAGES; p++) begin
            if (addr == A_PCFG && page_q == PAGE_W'(p)) rd_data = cfg_q[p];
        end
    end

    for (genvar g = 0; g < N_PAGES; g++) begin : g_cfg_out
        assign page_cfg_o[g*DATA_W +: DATA_W] = cfg_q[g];
    end

    assign an_enable_o  = an_q;
    assign an_restart_o = restart_q;
    assign loopback_o   = loop_q;
    assign speed_o      = speed_q;
    assign duplex_o     = duplex_q;
    assign irq_o        = |(sts_q & en_q);
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top of the management-port slave: pin synchronizer, frame engine and
// register bank. Everything runs on clk; mdc_i is oversampled.
// Assumes clk is at least 4x the management clock and ev_i is clk-synchronous.
module mdio_mgmt_slave
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned N_PAGES     = 2,
    parameter int unsigned N_EVT       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mdc_i,
    input  logic                      mdio_i,
    output logic                      mdio_o,
    output logic                      mdio_oe_o,
    input  logic [4:0]                phy_addr_i,
    input  logic                      link_up_i,
    input  logic                      remote_fault_i,
    input  logic [N_EVT-1:0]          ev_i,
    output logic                      an_enable_o,
    output logic                      an_restart_o,
    output logic                      loopback_o,
    output logic                      speed_o,
    output logic                      duplex_o,
    output logic [N_PAGES*DATA_W-1:0] page_cfg_o,
    output logic                      irq_o
);
    logic              bit_stb, bit_val;
    logic              rd_stb, wr_stb;
    logic [REG_AW-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc_i   (mdc_i),
        .mdio_i  (mdio_i),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    mdio_frame_engine u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .phy_addr_i (phy_addr_i),
        .rd_data    (rd_data),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    mdio_reg_bank #(.N_PAGES(N_PAGES), .N_EVT(N_EVT)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_stb         (rd_stb),
        .wr_stb         (wr_stb),
        .addr           (reg_addr),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .link_up_i      (link_up_i),
        .remote_fault_i (remote_fault_i),
        .ev_i           (ev_i),
        .an_enable_o    (an_enable_o),
        .an_restart_o   (an_restart_o),
        .loopback_o     (loopback_o),
        .speed_o        (speed_o),
        .duplex_o       (duplex_o),
        .page_cfg_o     (page_cfg_o),
        .irq_o          (irq_o)
    );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
// Property checker for the management-port slave, bound to the top.
// Relates the engine's strobes to the bank's outputs and the pin drive.
module mdio_mgmt_slave_chk
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned N_EVT = 4,
    parameter int unsigned CFG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdio_o,
    input logic              mdio_oe_o,
    input logic              an_restart_o,
    input logic              an_enable_o,
    input logic              irq_o,
    input logic [N_EVT-1:0]  ev_i,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [REG_AW-1:0] reg_addr,
    input logic [CFG_W-1:0]  page_cfg_o
);
    // R2: the first driven bit of a reply is the turnaround zero.
    p_ta_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !mdio_o);

    // R6: the restart pulse lasts one cycle.
    p_restart_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |=> !an_restart_o);

    // R6: restart only with auto-negotiation enabled.
    p_restart_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |-> an_enable_o);

    // R4: no write is committed while a reply is on the line.
    p_no_wr_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !mdio_oe_o);

    // R4: the config words only change after a write strobe.
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(page_cfg_o));

    // R9: reading interrupt status with no new event drops the request.
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_addr == A_IRQ && ev_i == '0) |=> !irq_o);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
    .N_EVT (N_EVT),
    .CFG_W (N_PAGES * 16)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe_o),
    .an_restart_o (an_restart_o),
    .an_enable_o  (an_enable_o),
    .irq_o        (irq_o),
    .ev_i         (ev_i),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .reg_addr     (reg_addr),
    .page_cfg_o   (page_cfg_o)
);

// File: tb/mdio_mgmt_slave_tb.sv
// Bench for the management-port slave: acts as the station manager,
// sweeps the address space and pages, and exercises each access type.
module mdio_mgmt_slave_tb_top;
    localparam int N_PAGES = 2;
    localparam int N_EVT   = 4;
    localparam logic [4:0] MY_PHY = 5'b00001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic m_drv = 1'b1;
    logic m_val = 1'b1;
    logic mdio_o, mdio_oe_o, bus;
    logic link_up = 1'b1;
    logic rfault = 1'b0;
    logic [N_EVT-1:0] ev = '0;
    logic an_en, an_rs, loop, speed, duplex, irq;
    logic [N_PAGES*16-1:0] pcfg;

    int n_chk = 0;
    int n_fail = 0;
    int n_restart = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign bus = mdio_oe_o ? mdio_o : (m_drv ? m_val : 1'b1);

    mdio_mgmt_slave #(.N_PAGES(N_PAGES), .N_EVT(N_EVT)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mdc_i          (mdc),
        .mdio_i         (bus),
        .mdio_o         (mdio_o),
        .mdio_oe_o      (mdio_oe_o),
        .phy_addr_i     (MY_PHY),
        .link_up_i      (link_up),
        .remote_fault_i (rfault),
        .ev_i           (ev),
        .an_enable_o    (an_en),
        .an_restart_o   (an_rs),
        .loopback_o     (loop),
        .speed_o        (speed),
        .duplex_o       (duplex),
        .page_cfg_o     (pcfg),
        .irq_o          (irq)
    );

    always @(negedge clk) if (an_rs) n_restart++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic mdc_cycle(input logic drv, input logic val, output logic s_oe, output logic s_out);
        mdc = 1'b0; m_drv = drv; m_val = val;
        repeat (4) @(negedge clk);
        mdc = 1'b1; s_oe = mdio_oe_o; s_out = mdio_o;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic o, d;
        for (int i = n - 1; i >= 0; i--) mdc_cycle(1'b1, v[i], o, d);
    endtask

    task automatic preamble(input int n);
        logic o, d;
        for (int i = 0; i < n; i++) mdc_cycle(1'b1, 1'b1, o, d);
    endtask

    task automatic read_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] phy, input logic [4:0] ra,
                              output logic [15:0] data, output logic ok, output logic drove);
        logic o, d;
        preamble(pre);
        send_bits({18'b0, st, op, phy, ra}, 14);
        ok = 1'b1; drove = 1'b0; data = '0;
        mdc_cycle(1'b0, 1'b1, o, d);
        if (o) begin ok = 1'b0; drove = 1'b1; end
        mdc_cycle(1'b0, 1'b1, o, d);
        if (!o || d) ok = 1'b0;
        if (o) drove = 1'b1;
        for (int i = 0; i < 16; i++) begin
            mdc_cycle(1'b0, 1'b1, o, d);
            if (!o) ok = 1'b0;
            if (o) drove = 1'b1;
            data = {data[14:0], d};
        end
        mdc_cycle(1'b0, 1'b1, o, d);
        if (o) begin ok = 1'b0; drove = 1'b1; end
    endtask

    task automatic rd(input logic [4:0] ra, output logic [15:0] data);
        logic ok, drove;
        read_frame(32, 2'b01, 2'b10, MY_PHY, ra, data, ok, drove);
        check("R2 reply framing", {31'b0, ok}, 32'd1);
    endtask

    task automatic wr_bits(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] data, input int nbits);
        logic o, d;
        preamble(32);
        send_bits({16'b0, 2'b01, 2'b01, phy, ra, 2'b10}, 16);
        for (int i = 15; i >= 16 - nbits; i--) mdc_cycle(1'b1, data[i], o, d);
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] data);
        wr_bits(MY_PHY, ra, data, 16);
    endtask

    task automatic pulse_ev(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ev[idx] = 1'b1;
            @(negedge clk) ev[idx] = 1'b0;
        end
    endtask

    function automatic logic [15:0] pat(input int p);
        return 16'(16'hC3A5 ^ (p * 16'h1357));
    endfunction

    function automatic logic [15:0] exp_default(input int a);
        case (a)
            5'h00:   return 16'h3000;
            5'h01:   return 16'h7805;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic ok, drove;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 oe after reset", {31'b0, mdio_oe_o}, 0);
        check("R10 irq after reset", {31'b0, irq}, 0);
        check("R10 restart after reset", {31'b0, an_rs}, 0);
        check("R10 cfg after reset", pcfg, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 outputs after reset", {27'b0, loop, speed, an_en, duplex, an_rs}, 32'b01100);

        // R5 R6 R7 default sweep over all addresses on page 0
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            check($sformatf("R5 default read addr %0h", a), v, exp_default(a));
        end

        // R5 page sweep of the config word and the counter location
        for (int p = 0; p < 8; p++) begin
            wr(5'h13, 16'hFFF8 | 16'(p));
            rd(5'h13, v);
            check("R5 page readback", v, 32'(p));
            wr(5'h16, pat(p));
            rd(5'h16, v);
            check($sformatf("R5 config page %0d", p), v, (p < N_PAGES) ? pat(p) : 16'h0);
            rd(5'h15, v);
            check("R5 counter location per page", v, 0);
        end
        check("R5 config outputs", pcfg, {pat(1), pat(0)});
        wr(5'h13, 16'h0000);
        rd(5'h16, v);
        check("R5 page 0 config kept", v, pat(0));

        // R4 write lands only after the 16th data bit
        wr_bits(MY_PHY, 5'h16, 16'hA5A5, 15);
        check("R4 no commit after 15 bits", pcfg[15:0], pat(0));
        send_bits(32'h1, 1);
        repeat (2) @(negedge clk);
        check("R4 commit after 16 bits", pcfg[15:0], 16'hA5A5);

        // R4 read-only registers ignore writes
        wr(5'h01, 16'hFFFF);
        rd(5'h01, v);
        check("R4 status write ignored", v, 16'h7805);
        wr(5'h15, 16'hFFFF);
        rd(5'h15, v);
        check("R4 R8 counter write ignored", v, 0);

        // R3 foreign address: no drive, no write
        read_frame(32, 2'b01, 2'b10, 5'b00010, 5'h16, v, ok, drove);
        check("R3 foreign read not driven", {31'b0, drove}, 0);
        wr_bits(5'b10001, 5'h16, 16'h1234, 16);
        check("R3 foreign write ignored", pcfg[15:0], 16'hA5A5);

        // R1 bad start, bad opcode, short preamble
        read_frame(32, 2'b00, 2'b10, MY_PHY, 5'h16, v, ok, drove);
        check("R1 bad start not driven", {31'b0, drove}, 0);
        read_frame(32, 2'b01, 2'b11, MY_PHY, 5'h16, v, ok, drove);
        check("R1 bad opcode not driven", {31'b0, drove}, 0);
        send_bits(32'h0, 1);
        read_frame(31, 2'b01, 2'b10, MY_PHY, 5'h16, v, ok, drove);
        check("R1 short preamble not driven", {31'b0, drove}, 0);
        rd(5'h16, v);
        check("R1 recovers after bad frames", v, 16'hA5A5);

        // R6 restart with and without auto-negotiation enabled
        n_restart = 0;
        wr(5'h00, 16'h1200);
        repeat (2) @(negedge clk);
        check("R6 restart pulse count", n_restart, 1);
        rd(5'h00, v);
        check("R6 restart self-clears", v, 16'h1000);
        wr(5'h00, 16'h4300);
        repeat (2) @(negedge clk);
        check("R6 restart ignored with AN off", n_restart, 1);
        check("R6 control outputs", {28'b0, loop, speed, an_en, duplex}, 32'b1001);
        wr(5'h00, 16'h3000);

        // R7 latch-high remote fault
        @(negedge clk) rfault = 1'b1;
        repeat (3) @(negedge clk);
        rfault = 1'b0;
        rd(5'h01, v);
        check("R7 fault latched", v, 16'h7815);
        rd(5'h01, v);
        check("R7 fault cleared by read", v, 16'h7805);
        link_up = 1'b0;
        rd(5'h01, v);
        check("R7 link follows input", v, 16'h7801);
        link_up = 1'b1;

        // R8 error counter count, clear and saturation
        pulse_ev(0, 5);
        rd(5'h15, v);
        check("R8 count of 5", v, 5);
        rd(5'h15, v);
        check("R8 cleared by read", v, 0);
        pulse_ev(0, 300);
        rd(5'h15, v);
        check("R8 saturates at 255", v, 255);
        rd(5'h15, v);
        check("R8 clear after saturation", v, 0);

        // R9 interrupt status and gating
        rd(5'h12, v);
        check("R9 status from receive errors", v, 16'h0100);
        wr(5'h12, 16'h0002);
        pulse_ev(2, 1);
        @(negedge clk);
        check("R9 masked event no irq", {31'b0, irq}, 0);
        pulse_ev(1, 1);
        @(negedge clk);
        check("R9 enabled event raises irq", {31'b0, irq}, 1);
        rd(5'h12, v);
        check("R9 status and enables", v, 16'h0602);
        check("R9 irq dropped after read", {31'b0, irq}, 0);
        rd(5'h12, v);
        check("R9 status cleared", v, 16'h0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule